// File: doc/BRIEF.md
# Indirect Control/Status Register Port for a Network Controller

This block is the host-facing register file of a network controller. The host sees only two 16-bit locations. One is an index port and the other is a data port. Writing the index port picks one of four internal registers, and later accesses to the data port read or write that register. Reads are combinational from the selected location.

Register 0 is the main status word. It holds seven event flags, which the datapath sets with single-cycle strobes and the host clears by writing ones to them. It also holds two OR-summary bits, an interrupt enable, the receive and transmit run indicators, and four command bits. The command bits do not store anything. Each one produces a one-cycle pulse towards the datapath. Registers 1 and 2 together hold a 24-bit, word-aligned initialization-memory address. Register 3 holds three bus-configuration bits. The block drives a level interrupt output.

Top module: `nic_csr_port`

## Requirements
- R1: After reset, the index is 0, the data port reads 0x0000, irq is 0, cmd_pulse is 0, init_addr is 0 and bus_cfg is 0.
- R2: A write with host_asel=1 stores host_wdata[1:0] as the register index, and a read with host_asel=1 returns that index zero-extended. A read or write with host_asel=0 accesses the register that the index selects.
- R3: Register 0 bit 15 reads as the OR of bits 14 (babble), 13 (no heartbeat), 12 (missed frame) and 11 (memory error).
- R4: Register 0 bit 7 reads as the OR of bits 14, 12, 11, 10 (receive event), 9 (transmit event) and 8 (init done). Bit 13 does not contribute to it.
- R5: The event flags sit in register 0 bits 14..8. Strobe ev_set[i] sets flag bit 8+i. Writing a 1 to a flag bit of register 0 clears that flag, and writing a 0 leaves it unchanged.
- R6: When a set strobe and a host clear (either a write-one-to-clear or a stop command) reach the same flag in the same cycle, the flag ends up set.
- R7: Writing a 1 to register 0 bits 3 (transmit demand), 2 (stop), 1 (start) or 0 (initialize) drives cmd_pulse bit 3, 2, 1 or 0 high for exactly the following cycle. These bits always read as 0.
- R8: A start command sets bits 5 (receive on) and 4 (transmit on). A stop command clears both of them and all event flags. When a write carries both stop and start, stop wins.
- R9: Registers 1 to 3 accept writes only while bits 5 and 4 are both 0. Otherwise the write is ignored.
- R10: Register 1 holds address bits 15:1, and its bit 0 reads as 0. Register 2 holds address bits 23:16, and its bits 15:8 read as 0. init_addr equals {reg2[7:0], reg1}.
- R11: Register 0 bit 6 is a read/write interrupt enable. irq equals bit 7 AND bit 6.
- R12: Register 3 bits 2:0 drive bus_cfg[2:0] (byte swap, active-low address latch, byte control), and its bits 15:3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_asel | input | 1 | 1 = index port, 0 = data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the port chosen by host_asel |
| ev_set | input | 7 | Event strobes; bit i sets register 0 bit 8+i |
| cmd_pulse | output | 4 | One-cycle command pulses {txdemand, stop, start, init} |
| irq | output | 1 | Level interrupt |
| init_addr | output | 24 | Initialization-memory address |
| bus_cfg | output | 3 | {byte swap, latch polarity, byte control} |

## Verification
Two paths can reach the same event flag in the same cycle: a datapath set strobe and a host clear. The clear can be a write-one-to-clear or a stop command. The bench drives an ev_set bit and a data-port write to register 0 on the same clock edge, once for each kind of clear. It then reads register 0 back and expects the flag to remain set, with the summary bits and irq following from it. A second collision puts stop and start in the same write, and the run bits must end up cleared.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

   localparam int CSR_W     = 16;
   localparam int NUM_EV    = 7;
   localparam int EV_BASE   = 8;
   localparam int IDX_W     = 2;

   // event index inside the flag vector (flag i sits at bit EV_BASE+i)
   localparam int EV_INITDONE = 0;
   localparam int EV_TXEVT    = 1;
   localparam int EV_RXEVT    = 2;
   localparam int EV_MEMERR   = 3;
   localparam int EV_MISS     = 4;
   localparam int EV_NOHB     = 5;
   localparam int EV_BABBLE   = 6;

   // status bit positions
   localparam int B_ERR  = 15;
   localparam int B_INTR = 7;
   localparam int B_IEN  = 6;
   localparam int B_RXON = 5;
   localparam int B_TXON = 4;

   // command positions (also cmd_pulse indices)
   localparam int C_INIT  = 0;
   localparam int C_START = 1;
   localparam int C_STOP  = 2;
   localparam int C_TXDEM = 3;
   localparam int NUM_CMD = 4;

   localparam logic [NUM_EV-1:0] ERR_MASK  = 7'b111_1000;
   localparam logic [NUM_EV-1:0] INTR_MASK = 7'b101_1111;

   typedef enum logic [IDX_W-1:0] {
      IDX_STATUS  = 2'd0,
      IDX_ADDR_LO = 2'd1,
      IDX_ADDR_HI = 2'd2,
      IDX_BUSCFG  = 2'd3
   } csr_idx_e;

endpackage

// File: rtl/nic_csr_evflag.sv
module nic_csr_evflag #(
   parameter int NUM_EV = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EV-1:0] ev_set,
   input  logic [NUM_EV-1:0] clr_mask,
   input  logic              clr_all,
   output logic [NUM_EV-1:0] flags
);

   generate
      for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= 1'b0;
            else if (ev_set[i])
               q <= 1'b1;
            else if (clr_all || clr_mask[i])
               q <= 1'b0;
         end
         assign flags[i] = q;
      end
   endgenerate

endmodule

// File: rtl/nic_csr_status.sv
module nic_csr_status
   import nic_csr_pkg::*;
#(
   parameter int W = CSR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [W-1:0]       wdata,
   input  logic [NUM_EV-1:0]  ev_set,
   output logic [NUM_EV-1:0]  flags,
   output logic               ien,
   output logic               rxon,
   output logic               txon,
   output logic [NUM_CMD-1:0] cmd_pulse,
   output logic               irq,
   output logic [W-1:0]       rdata
);

   logic stop_wr, start_wr;
   logic err_sum, intr_sum;
   logic [NUM_EV-1:0] clr_mask;

   assign stop_wr  = wr_en && wdata[C_STOP];
   assign start_wr = wr_en && wdata[C_START];
   assign clr_mask = wr_en ? wdata[EV_BASE +: NUM_EV] : '0;

   nic_csr_evflag #(.NUM_EV(NUM_EV)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_set   (ev_set),
      .clr_mask (clr_mask),
      .clr_all  (stop_wr),
      .flags    (flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien       <= 1'b0;
         rxon      <= 1'b0;
         txon      <= 1'b0;
         cmd_pulse <= '0;
      end else begin
         cmd_pulse <= wr_en ? wdata[NUM_CMD-1:0] : '0;
         if (wr_en)
            ien <= wdata[B_IEN];
         if (stop_wr) begin
            rxon <= 1'b0;
            txon <= 1'b0;
         end else if (start_wr) begin
            rxon <= 1'b1;
            txon <= 1'b1;
         end
      end
   end

   assign err_sum  = |(flags & ERR_MASK);
   assign intr_sum = |(flags & INTR_MASK);
   assign irq      = intr_sum && ien;

   always_comb begin
      rdata                        = '0;
      rdata[B_ERR]                 = err_sum;
      rdata[EV_BASE +: NUM_EV]     = flags;
      rdata[B_INTR]                = intr_sum;
      rdata[B_IEN]                 = ien;
      rdata[B_RXON]                = rxon;
      rdata[B_TXON]                = txon;
   end

endmodule

// File: rtl/nic_csr_cfg.sv
module nic_csr_cfg #(
   parameter int W        = 16,
   parameter int IADDR_W  = 24,
   parameter int CFG_BITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                unlocked,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic                wr_bus,
   input  logic [W-1:0]        wdata,
   output logic [IADDR_W-1:0]  init_addr,
   output logic [CFG_BITS-1:0] bus_cfg,
   output logic [W-1:0]        rd_lo,
   output logic [W-1:0]        rd_hi,
   output logic [W-1:0]        rd_bus
);

   localparam int HI_W = IADDR_W - W;

   logic [W-2:0]        lo_q;
   logic [HI_W-1:0]     hi_q;
   logic [CFG_BITS-1:0] bus_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         bus_q <= '0;
      end else if (unlocked) begin
         if (wr_lo)  lo_q  <= wdata[W-1:1];
         if (wr_hi)  hi_q  <= wdata[HI_W-1:0];
         if (wr_bus) bus_q <= wdata[CFG_BITS-1:0];
      end
   end

   assign rd_lo     = {lo_q, 1'b0};
   assign rd_hi     = {{(W-HI_W){1'b0}}, hi_q};
   assign rd_bus    = {{(W-CFG_BITS){1'b0}}, bus_q};
   assign init_addr = {hi_q, lo_q, 1'b0};
   assign bus_cfg   = bus_q;

endmodule

// File: rtl/nic_csr_port.sv
module nic_csr_port
   import nic_csr_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int IADDR_W  = 24,
   parameter int CFG_BITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_wr,
   input  logic                host_asel,
   input  logic [DATA_W-1:0]   host_wdata,
   output logic [DATA_W-1:0]   host_rdata,
   input  logic [NUM_EV-1:0]   ev_set,
   output logic [NUM_CMD-1:0]  cmd_pulse,
   output logic                irq,
   output logic [IADDR_W-1:0]  init_addr,
   output logic [CFG_BITS-1:0] bus_cfg
);

   generate
      if (DATA_W != CSR_W) begin : g_bad_width
         $error("DATA_W must equal the status word width");
      end
      if (IADDR_W <= DATA_W || IADDR_W >= 2*DATA_W) begin : g_bad_iaddr
         $error("IADDR_W must lie strictly between DATA_W and 2*DATA_W");
      end
      if (CFG_BITS < 1 || CFG_BITS >= DATA_W) begin : g_bad_cfg
         $error("CFG_BITS out of range");
      end
   endgenerate

   csr_idx_e            sel_q;
   logic                data_wr;
   logic [NUM_EV-1:0]   st_flags;
   logic                st_ien, st_rxon, st_txon;
   logic [DATA_W-1:0]   rd_status, rd_lo, rd_hi, rd_bus;
   logic [DATA_W-1:0]   rd_data;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= IDX_STATUS;
      else if (host_wr && host_asel)
         sel_q <= csr_idx_e'(host_wdata[IDX_W-1:0]);
   end

   assign data_wr = host_wr && !host_asel;

   nic_csr_status #(.W(DATA_W)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (data_wr && (sel_q == IDX_STATUS)),
      .wdata     (host_wdata),
      .ev_set    (ev_set),
      .flags     (st_flags),
      .ien       (st_ien),
      .rxon      (st_rxon),
      .txon      (st_txon),
      .cmd_pulse (cmd_pulse),
      .irq       (irq),
      .rdata     (rd_status)
   );

   nic_csr_cfg #(.W(DATA_W), .IADDR_W(IADDR_W), .CFG_BITS(CFG_BITS)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .unlocked  (!(st_rxon || st_txon)),
      .wr_lo     (data_wr && (sel_q == IDX_ADDR_LO)),
      .wr_hi     (data_wr && (sel_q == IDX_ADDR_HI)),
      .wr_bus    (data_wr && (sel_q == IDX_BUSCFG)),
      .wdata     (host_wdata),
      .init_addr (init_addr),
      .bus_cfg   (bus_cfg),
      .rd_lo     (rd_lo),
      .rd_hi     (rd_hi),
      .rd_bus    (rd_bus)
   );

   always_comb begin
      unique case (sel_q)
         IDX_STATUS:  rd_data = rd_status;
         IDX_ADDR_LO: rd_data = rd_lo;
         IDX_ADDR_HI: rd_data = rd_hi;
         default:     rd_data = rd_bus;
      endcase
   end

   assign host_rdata = host_asel ? {{(DATA_W-IDX_W){1'b0}}, sel_q} : rd_data;

endmodule

// File: rtl/nic_csr_port_chk.sv
module nic_csr_port_chk
   import nic_csr_pkg::*;
#(
   parameter int IADDR_W  = 24,
   parameter int CFG_BITS = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                host_wr,
   input logic [NUM_EV-1:0]   ev_set,
   input logic [NUM_CMD-1:0]  cmd_pulse,
   input logic                irq,
   input logic [IADDR_W-1:0]  init_addr,
   input logic [CFG_BITS-1:0] bus_cfg,
   input logic [NUM_EV-1:0]   flags,
   input logic                ien,
   input logic                rxon,
   input logic                txon
);

   // R6: a strobe always leaves its flag set, whatever the host wrote
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_set != '0) |=> ((flags & $past(ev_set)) == $past(ev_set)));

   // R7: a command pulse only follows a host write
   p_cmd_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pulse != '0) |-> $past(host_wr));

   // R8: a stop pulse shows the run bits already low
   p_stop_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pulse[C_STOP] |-> (!rxon && !txon));

   // R9: configuration frozen while running
   p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rxon || txon) |=> ($stable(init_addr) && $stable(bus_cfg)));

   // R10: word alignment of the init address
   p_addr_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !init_addr[0]);

   // R11: interrupt needs enable and a contributing flag
   p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien && ((flags & INTR_MASK) != '0)));

   // R4: no-heartbeat alone never raises the interrupt
   p_nohb_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & ~(NUM_EV'(1) << EV_NOHB)) == '0) |-> !irq);

endmodule

bind nic_csr_port nic_csr_port_chk #(.IADDR_W(IADDR_W), .CFG_BITS(CFG_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_wr   (host_wr),
   .ev_set    (ev_set),
   .cmd_pulse (cmd_pulse),
   .irq       (irq),
   .init_addr (init_addr),
   .bus_cfg   (bus_cfg),
   .flags     (st_flags),
   .ien       (st_ien),
   .rxon      (st_rxon),
   .txon      (st_txon)
);

// File: tb/nic_csr_port_tb_top.sv
`timescale 1ns/1ps
module nic_csr_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_asel = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic [6:0]  ev_set = '0;
   logic [3:0]  cmd_pulse;
   logic        irq;
   logic [23:0] init_addr;
   logic [2:0]  bus_cfg;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   nic_csr_port dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_asel  (host_asel),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .ev_set     (ev_set),
      .cmd_pulse  (cmd_pulse),
      .irq        (irq),
      .init_addr  (init_addr),
      .bus_cfg    (bus_cfg)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic asel, input logic [15:0] d, input logic [6:0] ev = '0);
      host_asel  = asel;
      host_wdata = d;
      host_wr    = 1'b1;
      ev_set     = ev;
      @(negedge clk);
      host_wr    = 1'b0;
      ev_set     = '0;
   endtask

   task automatic rd(input logic asel, output logic [15:0] d);
      host_asel = asel;
      #1;
      d = host_rdata;
   endtask

   task automatic strobe(input logic [6:0] ev);
      ev_set = ev;
      @(negedge clk);
      ev_set = '0;
   endtask

   task automatic reg_write(input logic [1:0] idx, input logic [15:0] d);
      wr(1'b1, {14'd0, idx});
      wr(1'b0, d);
   endtask

   task automatic reg_read(input logic [1:0] idx, output logic [15:0] d);
      wr(1'b1, {14'd0, idx});
      rd(1'b0, d);
   endtask

   task automatic t_reset;
      logic [15:0] d;
      rd(1'b1, d);      chk("R1 index", d, 16'h0);
      rd(1'b0, d);      chk("R1 status", d, 16'h0);
      chk("R1 irq", irq, 0);
      chk("R1 cmd", cmd_pulse, 0);
      chk("R1 init_addr", init_addr, 0);
      chk("R1 bus_cfg", bus_cfg, 0);
   endtask

   task automatic t_select;
      logic [15:0] d;
      wr(1'b1, 16'h0003);
      rd(1'b1, d);      chk("R2 index readback", d, 16'h3);
      wr(1'b0, 16'h0005);
      rd(1'b0, d);      chk("R2 data port reg3", d, 16'h5);
      chk("R12 bus_cfg", bus_cfg, 3'h5);
      wr(1'b0, 16'hFFFF);
      rd(1'b0, d);      chk("R12 reg3 upper zero", d, 16'h0007);
   endtask

   task automatic t_iaddr;
      logic [15:0] d;
      reg_write(2'd1, 16'hFFFF);
      rd(1'b0, d);      chk("R10 reg1 bit0 zero", d, 16'hFFFE);
      reg_write(2'd2, 16'hFFFF);
      rd(1'b0, d);      chk("R10 reg2 upper zero", d, 16'h00FF);
      chk("R10 init_addr", init_addr, 24'hFFFFFE);
   endtask

   task automatic t_summary;
      logic [15:0] d;
      reg_write(2'd0, 16'h0040);
      strobe(7'b010_0000);      // no heartbeat
      rd(1'b0, d);      chk("R3 err from nohb, R4 intr excluded", d, 16'hA040);
      chk("R4 irq low on nohb", irq, 0);
      strobe(7'b000_0100);      // receive event
      rd(1'b0, d);      chk("R4 intr from rx event", d, 16'hA4C0);
      chk("R11 irq high", irq, 1);
   endtask

   task automatic t_w1c;
      logic [15:0] d;
      wr(1'b0, 16'h2040);
      rd(1'b0, d);      chk("R5 clear nohb", d, 16'h04C0);
      wr(1'b0, 16'h0040);
      rd(1'b0, d);      chk("R5 zero write keeps flag", d, 16'h04C0);
      wr(1'b0, 16'h0440);
      rd(1'b0, d);      chk("R5 clear rx event", d, 16'h0040);
      chk("R11 irq low after clear", irq, 0);
      wr(1'b0, 16'h0000);
      strobe(7'b000_0001);
      rd(1'b0, d);      chk("R11 enable off masks irq", d, 16'h0180);
      chk("R11 irq gated", irq, 0);
      wr(1'b0, 16'h0100);
   endtask

   task automatic t_collide;
      logic [15:0] d;
      wr(1'b0, 16'h0440, 7'b000_0100);
      rd(1'b0, d);      chk("R6 set beats w1c", d, 16'h04C0);
      chk("R11 irq after collision", irq, 1);
      wr(1'b0, 16'h0004, 7'b000_0010);
      rd(1'b0, d);      chk("R6 set beats stop clear", d, 16'h0280);
      wr(1'b0, 16'h0200);
      rd(1'b0, d);      chk("R5 cleared after collision", d, 16'h0000);
   endtask

   task automatic t_cmd;
      logic [15:0] d;
      wr(1'b0, 16'h0008);
      chk("R7 txdemand pulse", cmd_pulse, 4'b1000);
      rd(1'b0, d);      chk("R7 cmd bits read zero", d, 16'h0000);
      @(negedge clk);
      chk("R7 pulse one cycle", cmd_pulse, 4'b0000);
      wr(1'b0, 16'h0001);
      chk("R7 init pulse", cmd_pulse, 4'b0001);
   endtask

   task automatic t_run;
      logic [15:0] d;
      wr(1'b0, 16'h0002);
      chk("R7 start pulse", cmd_pulse, 4'b0010);
      rd(1'b0, d);      chk("R8 start sets run bits", d, 16'h0030);
      strobe(7'b001_0000);
      rd(1'b0, d);      chk("R8 miss while running", d, 16'h90B0);
      reg_write(2'd1, 16'h1234);
      chk("R9 write ignored while running", init_addr, 24'hFFFFFE);
      rd(1'b0, d);      chk("R9 reg1 unchanged", d, 16'hFFFE);
      reg_write(2'd3, 16'h0002);
      chk("R9 bus_cfg locked", bus_cfg, 3'h7);
      reg_write(2'd0, 16'h0004);
      rd(1'b0, d);      chk("R8 stop clears run and flags", d, 16'h0000);
      reg_write(2'd1, 16'h1234);
      chk("R9 write accepted when stopped", init_addr, 24'hFF1234);
      reg_write(2'd0, 16'h0006);
      rd(1'b0, d);      chk("R8 stop beats start", d, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_select();
      t_iaddr();
      t_summary();
      t_w1c();
      t_collide();
      t_cmd();
      t_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule